// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is the serial management master that reaches the registers of Ethernet PHYs over the two-wire management bus. It derives MDC from the system clock. It controls the shared data line through separate output, output-enable and input signals, so that the pad buffer can stay outside the block. A single-beat command port takes the operation, the PHY address, the register or device address, a 16-bit register address and the write data. When the transaction completes, the port returns the read data together with a one-cycle done pulse.

Two framing families are supported. Short-form transactions (Clause 22) are one frame each. Extended transactions (Clause 45) are an address frame that carries the 16-bit register address, followed by a read or write frame to the same PHY and device. On reads, the master checks the turnaround bit that the PHY returns. If the PHY fails to pull that bit low, the master clocks the line for a fixed number of extra bits to flush the PHY and returns all ones. A per-PHY mask input can exempt PHYs whose turnaround is known to be broken.

Timing is set by two parameters, counted in system clock cycles: the MDC half period for driven bits, and a longer MDC high time for bits the PHY drives. The default values give a half period of 260 ns and a high time of 360 ns at 50 MHz.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and between transactions, MDC is low, the output enable is low, busy is low and done is low.
- R2: Every frame drives PRE_LEN (default 32) one bits, then a 2-bit start field, a 2-bit opcode, the 5-bit PHY address and the 5-bit register/device address, all MSB first. Short-form frames use start 01, with opcode 10 for read and 01 for write (defaults of C22_RD_OP and C22_WR_OP).
- R3: A short-form write drives turnaround 1 then 0 and then the 16 data bits MSB first. It then gives one clock with the output enable low, for 65 MDC clocks in total at the default preamble length.
- R4: A short-form read drops the output enable after the address fields. It samples the turnaround bit, then samples 16 data bits MSB first, then gives one more clock, for 64 MDC clocks in total. When the turnaround bit is 0, the returned data is the 16 sampled bits.
- R5: If the sampled turnaround bit is 1 and the bit of the ignore mask selected by the PHY address is 0, the master gives FLUSH_LEN (default 32) more released clocks after the turnaround, 79 in total, and returns 16'hFFFF.
- R6: If the sampled turnaround bit is 1 and the mask bit for that PHY is 1, the read continues normally and returns the sampled data.
- R7: An extended transaction is an address frame followed by a data frame, both with start 00 and the same PHY and device address. The address frame uses opcode 00 and carries the register address in place of write data. The data frame uses opcode 11 for read or 01 for write. This gives 130 clocks for a write and 129 for a read.
- R8: MDC stays high for HALF_CYC cycles on driven bits and for RD_HIGH_CYC cycles on released bits. MDIO output and enable change only while MDC is low. Read samples are taken on the system clock edge at which MDC falls.
- R9: Busy rises in the cycle after a request is accepted and falls in the same cycle that done pulses for one cycle with the read data valid. A write returns zero data. A request presented while busy is ignored and changes neither the ongoing frame nor what follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request strobe, accepted when busy is low |
| cmd_op | input | 2 | 0 short read, 1 short write, 2 extended read, 3 extended write |
| cmd_phy | input | 5 | PHY address |
| cmd_dev | input | 5 | Register address (short form) or device address (extended) |
| cmd_reg | input | 16 | Register address sent in the extended address frame |
| cmd_wdata | input | 16 | Write data |
| ta_ignore | input | 32 | Per-PHY mask: 1 skips the turnaround check for that PHY |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid while done is high |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven onto the line |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Data sampled from the line |

## Verification
Short-form writes and reads are swept over all 32 PHY addresses, each with a different register address and data word, so that a swapped, shifted or reversed field shows up as a wrong bit at a known position. Read data also includes all-zero, all-one and single-end-bit words, which separate MSB-first from LSB-first capture and off-by-one sampling. Turnaround is driven both low and high, with the mask bit both clear and set, which separates the normal, flushing and exempt paths by the frame length and the returned word. Extended reads and writes, one of them with a failed turnaround, and a request injected mid-frame show the two-frame sequencing and the busy lockout.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int PHY_AW  = 5;
   localparam int DEV_AW  = 5;
   localparam int DATA_W  = 16;
   localparam int HDR_FLD = 4 + PHY_AW + DEV_AW;

   typedef enum logic [1:0] {
      OP_C22_RD = 2'd0,
      OP_C22_WR = 2'd1,
      OP_C45_RD = 2'd2,
      OP_C45_WR = 2'd3
   } mdio_op_e;
endpackage

// File: rtl/mdio_bit_cell.sv
module mdio_bit_cell #(
   parameter int HALF_CYC    = 13,
   parameter int RD_HIGH_CYC = 18
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_req,
   input  logic bit_drive,
   input  logic bit_val,
   output logic mdc,
   output logic mdio_o,
   output logic mdio_oe,
   output logic bit_last
);
   localparam int CNT_MAX = (RD_HIGH_CYC > HALF_CYC) ? RD_HIGH_CYC : HALF_CYC;
   localparam int CW      = $clog2(CNT_MAX + 1);

   typedef enum logic [1:0] {C_IDLE, C_LOW, C_HIGH} cell_st_e;

   cell_st_e        st;
   logic [CW-1:0]   cnt;
   logic [CW-1:0]   high_load;

   generate
      if (RD_HIGH_CYC == HALF_CYC) begin : g_even
         assign high_load = CW'(HALF_CYC - 1);
      end else begin : g_stretch
         assign high_load = mdio_oe ? CW'(HALF_CYC - 1) : CW'(RD_HIGH_CYC - 1);
      end
   endgenerate

   assign bit_last = (st == C_HIGH) && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= C_IDLE;
         cnt     <= '0;
         mdc     <= 1'b0;
         mdio_o  <= 1'b0;
         mdio_oe <= 1'b0;
      end else begin
         case (st)
            C_IDLE: begin
               if (bit_req) begin
                  st      <= C_LOW;
                  cnt     <= CW'(HALF_CYC - 1);
                  mdio_o  <= bit_drive & bit_val;
                  mdio_oe <= bit_drive;
               end
            end
            C_LOW: begin
               if (cnt == '0) begin
                  st  <= C_HIGH;
                  mdc <= 1'b1;
                  cnt <= high_load;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: begin
               if (cnt == '0) begin
                  st  <= C_IDLE;
                  mdc <= 1'b0;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
         endcase
      end
   end

   logic [CW:0] hi_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hi_run <= '0;
      else if (mdc) hi_run <= hi_run + 1'b1;
      else          hi_run <= '0;
   end

   // R8
   hold_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

   // R8
   high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdc) |-> (hi_run == (mdio_oe ? (CW+1)'(HALF_CYC) : (CW+1)'(RD_HIGH_CYC))));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int         PRE_LEN   = 32,
   parameter int         FLUSH_LEN = 32,
   parameter logic [1:0] C22_RD_OP = 2'b10,
   parameter logic [1:0] C22_WR_OP = 2'b01
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  mdio_op_e             cmd_op,
   input  logic [PHY_AW-1:0]    cmd_phy,
   input  logic [DEV_AW-1:0]    cmd_dev,
   input  logic [DATA_W-1:0]    cmd_reg,
   input  logic [DATA_W-1:0]    cmd_wdata,
   input  logic [2**PHY_AW-1:0] ta_ignore,
   input  logic                 mdio_i,
   input  logic                 bit_last,
   output logic                 bit_req,
   output logic                 bit_drive,
   output logic                 bit_val,
   output logic                 busy,
   output logic                 done,
   output logic [DATA_W-1:0]    rdata
);
   localparam int HDR = PRE_LEN + HDR_FLD;
   localparam int IW  = $clog2(HDR + FLUSH_LEN + DATA_W + 4);
   localparam logic [IW-1:0] PRE_I   = IW'(PRE_LEN);
   localparam logic [IW-1:0] HDR_I   = IW'(HDR);
   localparam logic [IW-1:0] DEND_I  = IW'(HDR + DATA_W);
   localparam logic [IW-1:0] WLAST_I = IW'(HDR + DATA_W + 2);
   localparam logic [IW-1:0] RLAST_I = IW'(HDR + DATA_W + 1);
   localparam logic [IW-1:0] FLAST_I = IW'(HDR + FLUSH_LEN);

   logic              active, second, ta_bad;
   logic [IW-1:0]     idx, rel, last_idx;
   mdio_op_e          op_r;
   logic [PHY_AW-1:0] phy_r;
   logic [DEV_AW-1:0] dev_r;
   logic [DATA_W-1:0] reg_r, wd_r, shreg, rdata_r;
   logic              done_r;
   logic              is_c45, addr_frm, rd_frm;
   logic [3:0]        st_op;
   logic [HDR_FLD-1:0] hdr_tail;
   logic [DATA_W-1:0] payload;

   assign is_c45   = (op_r == OP_C45_RD) || (op_r == OP_C45_WR);
   assign addr_frm = is_c45 && !second;
   assign rd_frm   = !addr_frm && ((op_r == OP_C22_RD) || (op_r == OP_C45_RD));

   always_comb begin
      case (op_r)
         OP_C22_RD: st_op = {2'b01, C22_RD_OP};
         OP_C22_WR: st_op = {2'b01, C22_WR_OP};
         OP_C45_RD: st_op = second ? 4'b0011 : 4'b0000;
         default:   st_op = second ? 4'b0001 : 4'b0000;
      endcase
   end

   assign hdr_tail = {st_op, phy_r, dev_r};
   assign payload  = addr_frm ? reg_r : wd_r;
   assign rel      = idx - HDR_I;
   assign last_idx = !rd_frm ? WLAST_I : (ta_bad ? FLAST_I : RLAST_I);
   assign bit_req  = active;

   always_comb begin
      bit_drive = 1'b0;
      bit_val   = 1'b0;
      if (idx < PRE_I) begin
         bit_drive = 1'b1;
         bit_val   = 1'b1;
      end else if (idx < HDR_I) begin
         bit_drive = 1'b1;
         for (int j = 0; j < HDR_FLD; j++)
            if (idx == IW'(HDR - 1 - j)) bit_val = hdr_tail[j];
      end else if (!rd_frm) begin
         if (rel == IW'(0)) begin
            bit_drive = 1'b1;
            bit_val   = 1'b1;
         end else if (rel == IW'(1)) begin
            bit_drive = 1'b1;
         end else if (rel < IW'(DATA_W + 2)) begin
            bit_drive = 1'b1;
            for (int j = 0; j < DATA_W; j++)
               if (rel == IW'(DATA_W + 1 - j)) bit_val = payload[j];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         second  <= 1'b0;
         ta_bad  <= 1'b0;
         idx     <= '0;
         op_r    <= OP_C22_RD;
         phy_r   <= '0;
         dev_r   <= '0;
         reg_r   <= '0;
         wd_r    <= '0;
         shreg   <= '0;
         rdata_r <= '0;
         done_r  <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (!active) begin
            if (cmd_valid) begin
               op_r   <= cmd_op;
               phy_r  <= cmd_phy;
               dev_r  <= cmd_dev;
               reg_r  <= cmd_reg;
               wd_r   <= cmd_wdata;
               active <= 1'b1;
               second <= 1'b0;
               ta_bad <= 1'b0;
               idx    <= '0;
               shreg  <= '0;
            end
         end else if (bit_last) begin
            if (rd_frm && (idx == HDR_I) && mdio_i && !ta_ignore[phy_r])
               ta_bad <= 1'b1;
            if (rd_frm && !ta_bad && (idx > HDR_I) && (idx <= DEND_I))
               shreg <= {shreg[DATA_W-2:0], mdio_i};
            if (idx == last_idx) begin
               if (addr_frm) begin
                  second <= 1'b1;
                  idx    <= '0;
               end else begin
                  active  <= 1'b0;
                  done_r  <= 1'b1;
                  rdata_r <= !rd_frm ? '0 : (ta_bad ? '1 : shreg);
               end
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   assign busy  = active;
   assign done  = done_r;
   assign rdata = rdata_r;

   // R9
   busy_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> done_r);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_r |-> !active);

   // R5
   flush_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_r && ta_bad) |-> (rdata_r == '1));

   // R4
   read_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && rd_frm && (idx >= HDR_I)) |-> !bit_drive);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int         HALF_CYC    = 13,
   parameter int         RD_HIGH_CYC = 18,
   parameter int         PRE_LEN     = 32,
   parameter int         FLUSH_LEN   = 32,
   parameter logic [1:0] C22_RD_OP   = 2'b10,
   parameter logic [1:0] C22_WR_OP   = 2'b01
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [1:0]           cmd_op,
   input  logic [PHY_AW-1:0]    cmd_phy,
   input  logic [DEV_AW-1:0]    cmd_dev,
   input  logic [DATA_W-1:0]    cmd_reg,
   input  logic [DATA_W-1:0]    cmd_wdata,
   input  logic [2**PHY_AW-1:0] ta_ignore,
   output logic                 busy,
   output logic                 done,
   output logic [DATA_W-1:0]    rdata,
   output logic                 mdc,
   output logic                 mdio_o,
   output logic                 mdio_oe,
   input  logic                 mdio_i
);
   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least 1");
      end
      if (RD_HIGH_CYC < HALF_CYC) begin : g_bad_rdhigh
         $error("RD_HIGH_CYC must not be shorter than HALF_CYC");
      end
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("PRE_LEN must be at least 1");
      end
      if (FLUSH_LEN < 1) begin : g_bad_flush
         $error("FLUSH_LEN must be at least 1");
      end
   endgenerate

   logic bit_req, bit_drive, bit_val, bit_last;

   mdio_frame_seq #(
      .PRE_LEN   (PRE_LEN),
      .FLUSH_LEN (FLUSH_LEN),
      .C22_RD_OP (C22_RD_OP),
      .C22_WR_OP (C22_WR_OP)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (mdio_op_e'(cmd_op)),
      .cmd_phy   (cmd_phy),
      .cmd_dev   (cmd_dev),
      .cmd_reg   (cmd_reg),
      .cmd_wdata (cmd_wdata),
      .ta_ignore (ta_ignore),
      .mdio_i    (mdio_i),
      .bit_last  (bit_last),
      .bit_req   (bit_req),
      .bit_drive (bit_drive),
      .bit_val   (bit_val),
      .busy      (busy),
      .done      (done),
      .rdata     (rdata)
   );

   mdio_bit_cell #(
      .HALF_CYC    (HALF_CYC),
      .RD_HIGH_CYC (RD_HIGH_CYC)
   ) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_req   (bit_req),
      .bit_drive (bit_drive),
      .bit_val   (bit_val),
      .mdc       (mdc),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .bit_last  (bit_last)
   );

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
   localparam int HALF = 2;
   localparam int RDH  = 3;
   localparam int PRE  = 32;
   localparam int FL   = 32;
   localparam int CAP  = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic [4:0]  cmd_phy = '0, cmd_dev = '0;
   logic [15:0] cmd_reg = '0, cmd_wdata = '0;
   logic [31:0] ta_ignore = '0;
   logic        busy, done, mdc, mdio_o, mdio_oe;
   logic [15:0] rdata;
   logic        mdio_i = 1'b1;

   always #10 clk = ~clk;

   mdio_master #(.HALF_CYC(HALF), .RD_HIGH_CYC(RDH), .PRE_LEN(PRE), .FLUSH_LEN(FL)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_phy(cmd_phy), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
      .ta_ignore(ta_ignore), .busy(busy), .done(done), .rdata(rdata),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

   int tests = 0, fails = 0;
   logic exp_oe [CAP];
   logic exp_v  [CAP];
   logic cap_oe [CAP];
   logic cap_v  [CAP];
   logic resp   [CAP];
   int   cap_hi [CAP];
   int   ep = 0, n = 0, hi_cnt = 0;
   logic mdc_q = 1'b0, busy_q = 1'b0;

   // line model: capture each rising MDC, answer from resp[]
   always @(negedge clk) begin
      if (busy && !busy_q) n = 0;
      if (mdc && !mdc_q) begin
         if (n < CAP) begin
            cap_oe[n] = mdio_oe;
            cap_v[n]  = mdio_o;
            mdio_i    = resp[n];
         end
         n++;
         hi_cnt = 1;
      end else if (mdc) begin
         hi_cnt++;
      end else if (mdc_q && n > 0 && n <= CAP) begin
         cap_hi[n-1] = hi_cnt;
      end
      mdc_q  = mdc;
      busy_q = busy;
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic put(input logic oe, input logic v);
      exp_oe[ep] = oe;
      exp_v[ep]  = v;
      ep++;
   endtask

   task automatic frame(input logic [1:0] st, input logic [1:0] opc, input logic [4:0] ph,
                        input logic [4:0] dv, input logic [15:0] pl, input bit rd,
                        input logic ta, input bit bad, input logic [15:0] rv);
      for (int i = 0; i < PRE; i++) put(1'b1, 1'b1);
      put(1'b1, st[1]); put(1'b1, st[0]);
      put(1'b1, opc[1]); put(1'b1, opc[0]);
      for (int i = 4; i >= 0; i--) put(1'b1, ph[i]);
      for (int i = 4; i >= 0; i--) put(1'b1, dv[i]);
      if (!rd) begin
         put(1'b1, 1'b1); put(1'b1, 1'b0);
         for (int i = 15; i >= 0; i--) put(1'b1, pl[i]);
         put(1'b0, 1'b0);
      end else begin
         resp[ep] = ta;
         put(1'b0, 1'b0);
         if (bad) begin
            for (int i = 0; i < FL; i++) put(1'b0, 1'b0);
         end else begin
            for (int i = 15; i >= 0; i--) begin
               resp[ep] = rv[i];
               put(1'b0, 1'b0);
            end
            put(1'b0, 1'b0);
         end
      end
   endtask

   // op: 0 short read, 1 short write, 2 extended read, 3 extended write
   task automatic run(input logic [1:0] op, input logic [4:0] ph, input logic [4:0] dv,
                      input logic [15:0] rg, input logic [15:0] wd, input logic [15:0] rv,
                      input logic ta, input bit inject, input string req);
      bit rd, c45, bad, mism;
      logic [15:0] exp_rd;
      logic [1:0] opc;
      int cyc, bad_i, hi_bad;
      rd  = (op == 2'd0) || (op == 2'd2);
      c45 = op[1];
      bad = rd && ta && !ta_ignore[ph];
      ep  = 0;
      for (int i = 0; i < CAP; i++) resp[i] = 1'b1;
      if (c45) frame(2'b00, 2'b00, ph, dv, rg, 1'b0, 1'b0, 1'b0, 16'h0);
      case (op)
         2'd0: opc = 2'b10;
         2'd1: opc = 2'b01;
         2'd2: opc = 2'b11;
         default: opc = 2'b01;
      endcase
      frame(c45 ? 2'b00 : 2'b01, opc, ph, dv, wd, rd, ta, bad, rv);
      exp_rd = !rd ? 16'h0 : (bad ? 16'hFFFF : rv);

      @(negedge clk); #1;
      cmd_op = op; cmd_phy = ph; cmd_dev = dv; cmd_reg = rg; cmd_wdata = wd;
      cmd_valid = 1'b1;
      @(negedge clk); #1;
      cmd_valid = 1'b0;
      chk(busy === 1'b1, "R9", "busy after accept", busy, 1);
      cyc = 0;
      while (done !== 1'b1 && cyc < 5000) begin
         @(negedge clk); #1;
         cyc++;
         if (inject && cyc == 40) begin
            cmd_op = 2'd0; cmd_phy = ~ph; cmd_dev = ~dv; cmd_valid = 1'b1;
         end else if (inject && cyc == 41) begin
            cmd_valid = 1'b0;
         end
      end
      chk(done === 1'b1, req, "done seen", done, 1);
      chk(busy === 1'b0, "R9", "busy low with done", busy, 0);
      chk(rdata === exp_rd, req, "read data", rdata, exp_rd);
      chk(n == ep, req, "MDC clock count", n, ep);
      mism = 1'b0; bad_i = -1; hi_bad = -1;
      for (int i = 0; i < ep && i < CAP; i++) begin
         if (!mism && (cap_oe[i] !== exp_oe[i] || (exp_oe[i] && cap_v[i] !== exp_v[i]))) begin
            mism = 1'b1; bad_i = i;
         end
         if (hi_bad < 0 && cap_hi[i] != (exp_oe[i] ? HALF : RDH)) hi_bad = i;
      end
      chk(!mism, req, "frame bit index (R2)", bad_i, -1);
      chk(hi_bad < 0, "R8", "MDC high length bit index", hi_bad, -1);
      @(negedge clk); #1;
      chk(done === 1'b0, "R9", "done single cycle", done, 0);
      if (inject) begin
         repeat (20) begin
            @(negedge clk); #1;
         end
         chk(busy === 1'b0 && n == ep, "R9", "request during busy ignored", n, ep);
      end
   endtask

   initial begin
      repeat (1000000) @(posedge clk);
   end

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      tests++; fails++;
      $display("FAIL R9 watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1", "line idle in reset", {mdc, mdio_oe}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk(busy === 1'b0 && done === 1'b0, "R1", "port idle", {busy, done}, 0);
      chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1", "line idle", {mdc, mdio_oe}, 0);

      for (int p = 0; p < 32; p++)
         run(2'd1, 5'(p), 5'((p * 7) % 32), 16'h0, 16'((p * 16'h1357) ^ 16'hC0DE), 16'h0, 1'b0, 1'b0, "R3");
      for (int p = 0; p < 32; p++)
         run(2'd0, 5'(p), 5'(31 - p), 16'h0, 16'h0, 16'((p * 16'h0F1D) + 16'h8001), 1'b0, 1'b0, "R4");
      run(2'd0, 5'd1, 5'd2, 16'h0, 16'h0, 16'h0000, 1'b0, 1'b0, "R4");
      run(2'd0, 5'd1, 5'd2, 16'h0, 16'h0, 16'hFFFF, 1'b0, 1'b0, "R4");
      run(2'd0, 5'd1, 5'd2, 16'h0, 16'h0, 16'h8000, 1'b0, 1'b0, "R4");
      run(2'd0, 5'd1, 5'd2, 16'h0, 16'h0, 16'h0001, 1'b0, 1'b0, "R4");

      run(2'd3, 5'd5, 5'd30, 16'hBEEF, 16'h1234, 16'h0, 1'b0, 1'b0, "R7");
      run(2'd2, 5'd17, 5'd1, 16'h0001, 16'h0, 16'h5AA5, 1'b0, 1'b0, "R7");
      for (int k = 0; k < 4; k++)
         run(2'd2, 5'(k * 8 + 3), 5'(k + 1), 16'(16'h8000 >> (k * 5)), 16'h0, 16'(16'h0001 << (k * 5)), 1'b0, 1'b0, "R7");

      run(2'd0, 5'd3, 5'd4, 16'h0, 16'h0, 16'h1111, 1'b1, 1'b0, "R5");
      run(2'd2, 5'd12, 5'd7, 16'h4321, 16'h0, 16'h2222, 1'b1, 1'b0, "R5");
      ta_ignore = 32'h0000_0200;
      run(2'd0, 5'd9, 5'd6, 16'h0, 16'h0, 16'h3C3C, 1'b1, 1'b0, "R6");
      run(2'd0, 5'd8, 5'd6, 16'h0, 16'h0, 16'h3C3C, 1'b1, 1'b0, "R5");
      ta_ignore = '0;

      run(2'd1, 5'd21, 5'd13, 16'h0, 16'hA5C3, 16'h0, 1'b0, 1'b1, "R9");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule